// File: doc/BRIEF.md
# Trigger-Windowed Conversion Enable Controller

This block decides when a sampling front end may convert. Software loads a sample count and arms a sequence, and the block then drives a conversion-enable output. One external trigger input is used in either of two modes. In pretrigger mode, conversions are enabled as soon as the sequence is armed. The trigger edge only starts a down-counter that ends the window after the programmed number of conversions. This way, samples from before and after the event are both captured. In posttrigger mode, the enable stays low until the trigger edge and then stays high for the programmed count.

The trigger is an asynchronous input. It is synchronized and its first rising edge is taken once per armed sequence, so later edges in the same sequence change nothing. Conversion pulses from the converter timing logic decrement the counter while the post-trigger window is open. A done flag reports the end of the window, and a busy flag covers the span from arming to completion.

Top module: `acq_trig_ctrl`

## Requirements
- R1: After synchronous reset, conv_en_o, done_o and busy_o are all low.
- R2: Arming with pre_mode_i set raises conv_en_o and busy_o in the cycle after arm_i. Conversion pulses that arrive before the trigger edge are not counted.
- R3: Arming with only post_mode_i set keeps conv_en_o low and raises busy_o. If trig_i rises between two clock edges, conv_en_o goes high after the third rising clock edge that follows, and not after the second.
- R4: Once the trigger edge has been taken with a loaded count N>0, conv_en_o stays high through N-1 conversion pulses. After the clock edge that samples the Nth pulse, conv_en_o and busy_o are low and done_o is high.
- R5: After the first trigger edge of a sequence, further trig_i transitions do not change the window or the count.
- R6: A loaded count of zero ends the sequence as soon as the trigger edge is taken, three clock edges after trig_i rises: done_o goes high and conv_en_o and busy_o go low.
- R7: With neither mode bit set at arm time, the block stays idle: conv_en_o and busy_o stay low and trig_i has no effect.
- R8: If both mode bits are set at arm time, pretrigger behaviour applies (conv_en_o high right after arming).
- R9: A trig_i level that is already high at arm time is not a trigger edge. A low level and then a high level, each held for at least two clock periods, are recognized as an edge.
- R10: done_o stays high after completion until the next arm_i, and it is low in the cycle after arm_i.
- R11: The count is 16 bits wide. A count of 65535 gives a window of exactly 65535 conversion pulses.
- R12: load_i stores count_i for the next arm only. A load during a running sequence leaves that sequence's count unchanged.
- R13: arm_i during a running sequence restarts it from the waiting state, with the stored count, and a new trigger edge is needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_mode_i | input | 1 | Pretrigger mode select, sampled on arm |
| post_mode_i | input | 1 | Posttrigger mode select, sampled on arm |
| arm_i | input | 1 | One-cycle pulse that starts a sequence |
| load_i | input | 1 | Stores count_i as the post-trigger count |
| count_i | input | 16 | Post-trigger sample count |
| trig_i | input | 1 | Asynchronous external trigger |
| conv_i | input | 1 | One-cycle pulse per conversion |
| conv_en_o | output | 1 | Conversion enable window |
| done_o | output | 1 | Sequence complete |
| busy_o | output | 1 | Sequence armed and not yet complete |

## Verification
Arming takes effect one clock edge after arm_i, a conversion pulse takes effect one edge after it is sampled, and a trigger level change reaches the window three edges after it is applied: two synchronizer stages plus the state register. The driver steps one clock at a time and changes inputs just after a rising edge. It queues each expected output triple right after the edge where the change is due, and it also queues the value one edge earlier where a boundary is involved. The monitor compares the queued items at the following falling edge, so every sample lands half a period away from any update.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_PRE  = 2'd1,
        MODE_POST = 2'd2
    } acq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic conv_en;
        logic busy;
        logic done;
    } seq_out_t;

    // Pretrigger wins when both selects are set.
    function automatic acq_mode_e pick_mode(input logic pre, input logic post);
        if (pre)
            return MODE_PRE;
        else if (post)
            return MODE_POST;
        else
            return MODE_NONE;
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_i};
            prev_q <= sync_q[LAST];
        end
    end

    assign rise_o = sync_q[LAST] & ~prev_q;

    // A rising edge can never be reported on two consecutive cycles (R9).
    p_single_rise_r9: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/sample_counter.sv
module sample_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_i,
    input  logic [CNT_W-1:0] store_val_i,
    input  logic             start_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o,
    output logic             zero_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (store_i)
            hold_q <= store_val_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= hold_q;
        else if (dec_i)
            cnt_q <= cnt_q - ONE;
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == ONE);
    assign zero_o = (cnt_q == '0);

    // The live count only moves on a start or a decrement (R12).
    p_count_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !dec_i) |=> $stable(cnt_o));

    // The sequencer never asks for a decrement from zero (R4).
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        dec_i |-> (cnt_o != '0));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import acq_trig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arm_i,
    input  logic     pre_i,
    input  logic     post_i,
    input  logic     trig_rise_i,
    input  logic     conv_i,
    input  logic     cnt_last_i,
    input  logic     cnt_zero_i,
    output logic     start_o,
    output logic     dec_o,
    output seq_out_t out_o
);
    seq_state_e state_q;
    acq_mode_e  mode_q;
    acq_mode_e  arm_mode;
    logic       done_q;

    assign arm_mode = pick_mode(pre_i, post_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_NONE;
            done_q  <= 1'b0;
        end else if (arm_i) begin
            done_q  <= 1'b0;
            mode_q  <= arm_mode;
            state_q <= (arm_mode == MODE_NONE) ? ST_IDLE : ST_WAIT;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (trig_rise_i) begin
                        if (cnt_zero_i) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_COUNT;
                        end
                    end
                end
                ST_COUNT: begin
                    if (conv_i && cnt_last_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign start_o = arm_i;
    assign dec_o   = (state_q == ST_COUNT) && conv_i && !arm_i;

    always_comb begin
        out_o.conv_en = (state_q == ST_COUNT) ||
                        ((state_q == ST_WAIT) && (mode_q == MODE_PRE));
        out_o.busy    = (state_q != ST_IDLE);
        out_o.done    = done_q;
    end

    p_arm_clears_done_r10: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !out_o.done);

    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        out_o.done |-> !out_o.busy);

    p_done_closes_window_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_o.done) |-> (!out_o.conv_en && $past(out_o.busy)));

    p_pre_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (arm_i && pre_i) |=> out_o.conv_en);

    p_post_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (arm_i && !pre_i && post_i) |=> (!out_o.conv_en && out_o.busy));

    p_no_mode_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (arm_i && !pre_i && !post_i) |=> !out_o.busy);

endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
    import acq_trig_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_mode_i,
    input  logic             post_mode_i,
    input  logic             arm_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             trig_i,
    input  logic             conv_i,
    output logic             conv_en_o,
    output logic             done_o,
    output logic             busy_o
);
    logic             trig_rise;
    logic             cnt_start;
    logic             cnt_dec;
    logic             cnt_last;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    seq_out_t         seq_out;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .trig_i (trig_i),
        .rise_o (trig_rise)
    );

    sample_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .store_i     (load_i),
        .store_val_i (count_i),
        .start_i     (cnt_start),
        .dec_i       (cnt_dec),
        .cnt_o       (cnt_val),
        .last_o      (cnt_last),
        .zero_o      (cnt_zero)
    );

    seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .pre_i       (pre_mode_i),
        .post_i      (post_mode_i),
        .trig_rise_i (trig_rise),
        .conv_i      (conv_i),
        .cnt_last_i  (cnt_last),
        .cnt_zero_i  (cnt_zero),
        .start_o     (cnt_start),
        .dec_o       (cnt_dec),
        .out_o       (seq_out)
    );

    assign conv_en_o = seq_out.conv_en;
    assign done_o    = seq_out.done;
    assign busy_o    = seq_out.busy;

    // While the window is counting down, the remaining count is never zero (R4).
    p_window_count_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && conv_en_o && $past(busy_o) && !$past(arm_i) && !$past(conv_en_o))
        |-> (cnt_val != '0));

endmodule

// File: tb/test_acq_trig_ctrl.sv
`timescale 1ns/100ps
module test_acq_trig_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        pre_mode_i, post_mode_i, arm_i, load_i, trig_i, conv_i;
    logic [15:0] count_i;
    logic        conv_en_o, done_o, busy_o;

    always #2.5 clk = ~clk;

    acq_trig_ctrl i_acq_trig_ctrl (
        .clk(clk), .rst(rst),
        .pre_mode_i(pre_mode_i), .post_mode_i(post_mode_i),
        .arm_i(arm_i), .load_i(load_i), .count_i(count_i),
        .trig_i(trig_i), .conv_i(conv_i),
        .conv_en_o(conv_en_o), .done_o(done_o), .busy_o(busy_o)
    );

    typedef struct {
        string tag;
        logic  en;
        logic  dn;
        logic  bs;
    } exp_t;

    exp_t queue_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 0;

    // Monitor: compares queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (queue_q.size() > 0) begin
                exp_t e;
                e = queue_q.pop_front();
                checks++;
                if (conv_en_o !== e.en || done_o !== e.dn || busy_o !== e.bs) begin
                    failures++;
                    $display("FAIL %s: en/done/busy actual=%b%b%b expected=%b%b%b",
                             e.tag, conv_en_o, done_o, busy_o, e.en, e.dn, e.bs);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_out(input string tag, input logic en, input logic dn, input logic bs);
        exp_t e;
        e.tag = tag; e.en = en; e.dn = dn; e.bs = bs;
        queue_q.push_back(e);
    endtask

    task automatic load_count(input logic [15:0] n);
        count_i = n; load_i = 1'b1;
        tick(1);
        load_i = 1'b0;
    endtask

    task automatic arm(input logic pre, input logic post);
        pre_mode_i = pre; post_mode_i = post; arm_i = 1'b1;
        tick(1);
        arm_i = 1'b0; pre_mode_i = 1'b0; post_mode_i = 1'b0;
    endtask

    task automatic pulses(input int n);
        conv_i = 1'b1;
        tick(n);
        conv_i = 1'b0;
    endtask

    task automatic trig_low();
        trig_i = 1'b0;
        tick(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pre_mode_i = 0; post_mode_i = 0; arm_i = 0; load_i = 0;
        count_i = '0; trig_i = 0; conv_i = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_out("R1 reset", 0, 0, 0);

        // R7: no mode bit, trigger ignored
        load_count(16'd2);
        arm(0, 0);
        expect_out("R7 arm without mode", 0, 0, 0);
        trig_i = 1'b1; tick(4);
        expect_out("R7 trigger ignored", 0, 0, 0);
        pulses(3);
        expect_out("R7 pulses ignored", 0, 0, 0);
        trig_low();

        // R2 / R4 / R5: pretrigger with count 5
        load_count(16'd5);
        arm(1, 0);
        expect_out("R2 pre enable after arm", 1, 0, 1);
        pulses(4);
        expect_out("R2 pre pulses not counted", 1, 0, 1);
        trig_i = 1'b1; tick(3);
        pulses(2);
        trig_i = 1'b0; tick(3); trig_i = 1'b1; tick(3);
        expect_out("R5 retrigger ignored", 1, 0, 1);
        pulses(2);
        expect_out("R4 window open before last", 1, 0, 1);
        pulses(1);
        expect_out("R4 window closes on last", 0, 1, 0);
        tick(5);
        expect_out("R10 done holds", 0, 1, 0);
        trig_low();

        // R3 / R10: posttrigger count 3
        load_count(16'd3);
        arm(0, 1);
        expect_out("R3 post waits, R10 done cleared", 0, 0, 1);
        pulses(2);
        expect_out("R3 pulses before trigger", 0, 0, 1);
        trig_i = 1'b1; tick(2);
        expect_out("R3 not yet after two edges", 0, 0, 1);
        tick(1);
        expect_out("R3 open after third edge", 1, 0, 1);
        pulses(2);
        expect_out("R4 post before last", 1, 0, 1);
        pulses(1);
        expect_out("R4 post closes", 0, 1, 0);
        trig_low();

        // R6: zero count in pretrigger mode
        load_count(16'd0);
        arm(1, 0);
        expect_out("R6 pre enable", 1, 0, 1);
        trig_i = 1'b1; tick(2);
        expect_out("R6 before edge taken", 1, 0, 1);
        tick(1);
        expect_out("R6 zero count ends", 0, 1, 0);

        // R8: both mode bits; R9: trigger already high at arm
        load_count(16'd2);
        arm(1, 1);
        expect_out("R8 both bits act as pre", 1, 0, 1);
        tick(6);
        expect_out("R9 high level at arm is no edge", 1, 0, 1);
        pulses(3);
        expect_out("R9 still waiting", 1, 0, 1);
        // R12: load while running
        load_count(16'd7);
        trig_i = 1'b0; tick(2); trig_i = 1'b1; tick(3);
        pulses(1);
        expect_out("R12 old count kept", 1, 0, 1);
        pulses(1);
        expect_out("R9/R12 minimum-width edge, count 2 done", 0, 1, 0);
        trig_low();

        // R12: new count used at next arm
        arm(0, 1);
        trig_i = 1'b1; tick(3);
        pulses(6);
        expect_out("R12 stored count 7 not yet", 1, 0, 1);
        pulses(1);
        expect_out("R12 stored count 7 done", 0, 1, 0);
        trig_low();

        // R13: re-arm mid sequence
        load_count(16'd4);
        arm(1, 0);
        trig_i = 1'b1; tick(3);
        pulses(2);
        arm(1, 0);
        expect_out("R13 restart waits", 1, 0, 1);
        pulses(5);
        expect_out("R13 new trigger needed", 1, 0, 1);
        trig_low();
        trig_i = 1'b1; tick(3);
        pulses(3);
        expect_out("R13 full count again", 1, 0, 1);
        pulses(1);
        expect_out("R13 restarted sequence done", 0, 1, 0);
        trig_low();

        // R11: full 16-bit count
        load_count(16'hFFFF);
        arm(0, 1);
        trig_i = 1'b1; tick(3);
        pulses(65534);
        expect_out("R11 65534 pulses still open", 1, 0, 1);
        pulses(1);
        expect_out("R11 65535th pulse closes", 0, 1, 0);

        tick(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule